// File: doc/BRIEF.md
# Banked Video Memory Host Port

This block sits between a host bus and the word-organised memory of a video controller. The host issues single accesses carrying a byte address, an access size, write data and a bank select; the block checks them, decides where they land and answers one cycle later with a response strobe, read data and an error flag. Memory is arranged as two banks, each seen by the host as a window of 64K words. A word offset selects a word within the currently selected bank.

A small window of 16 words can be placed at any word offset. Accesses that fall inside it always reach the first 16 words of memory, whatever bank is selected, and it wins over banked memory. Its base resets to word offset 0x200 and is reloaded through a load strobe. A single write-only port address at word offset 0x40000 fills a 16-entry palette. Each write goes to the entry named by an internal index, which then advances and wraps from 15 to 0. The palette contents are driven out in parallel for the display side. Internal memory depth per bank is a parameter (`LOCAL_AW` word address bits, default 10), and offsets within a bank alias modulo that depth.

Top module: `vmem_host_if`

## Requirements
- R1: An access is legal only when its size code is 1 (16 bits; codes 0, 2 and 3 are 8, 32 bits and reserved) and byte address bit 0 is 0. Any other access is flagged as an error.
- R2: An access whose bank select is 2 or more is flagged as an error.
- R3: With word offset = byte address / 2, an access at word offset 0x10000 or above is flagged as an error, except a write to the palette port. Offset 0xFFFF is legal.
- R4: When base <= offset < base+16, the access targets memory word (offset - base) of bank 0, regardless of the bank select.
- R5: Any other legal non-palette access targets word `bank*2^LOCAL_AW + (offset mod 2^LOCAL_AW)`. A read returns the last value written to that word.
- R6: A legal write to word offset 0x40000 stores its data in the palette entry at the current index, then advances the index modulo 16. Entry i appears on `pal_o[16*i +: 16]`. Nothing else changes the palette.
- R7: A read at word offset 0x40000 is an error.
- R8: An access flagged as an error changes neither memory, the palette nor the palette index.
- R9: After reset the window base is 0x200, the palette index is 0, all palette entries are 0 and the response outputs are 0.
- R10: A base load takes effect from the next cycle. An access in the same cycle as the load decodes against the old base.
- R11: Every request yields `rsp_valid_o` exactly one cycle later, and `rsp_valid_o` is low otherwise. `err_o` is high only with `rsp_valid_o`. `rdata_o` is 0 for writes and errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 20 | Byte address |
| size_i | input | 2 | Size code: 0 = 8 bit, 1 = 16 bit, 2 = 32 bit, 3 = reserved |
| wdata_i | input | 16 | Write data |
| bank_i | input | 2 | Current bank select |
| base_ld_i | input | 1 | Load strobe for the window base |
| base_i | input | 19 | New window base (word offset) |
| rsp_valid_o | output | 1 | Response strobe, one cycle after request |
| rdata_o | output | 16 | Read data |
| err_o | output | 1 | Access error |
| pal_o | output | 256 | Palette entries, entry i at bits 16*i+15:16*i |

## Verification
Two functions can fall in the same cycle: a base relocation and an access. The bench issues directed accesses in the very cycle of a base load, at offsets that lie inside the new window but outside the old one. It expects these accesses to reach banked memory, and the next access at the same offset to reach the window. Random traffic also mixes base loads into requests, and every response is judged against a model that applies the load only after decoding that request.

// File: rtl/vmem_pkg.sv
package vmem_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_PAL  = 2'd1,
    TGT_WIN  = 2'd2,
    TGT_BANK = 2'd3
  } tgt_e;
endpackage

// File: rtl/vmem_decode.sv
module vmem_decode
  import vmem_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int BANK_W    = 2,
  parameter int N_BANKS   = 2,
  parameter int WIN_WORDS = 65536,
  parameter int REG_WORDS = 16,
  parameter int PAL_OFF   = 32'h40000,
  parameter int LOCAL_AW  = 10,
  localparam int OFF_W    = ADDR_W - 1,
  localparam int BSEL_W   = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int IDX_W    = BSEL_W + LOCAL_AW
) (
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFF_W-1:0]  base_i,
  output logic              err_o,
  output tgt_e              tgt_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [OFF_W-1:0] off;
  logic [OFF_W-1:0] rel;
  logic             pal_hit, size_bad, odd, bank_bad, range_bad, in_win;

  assign off       = addr_i[ADDR_W-1:1];
  assign rel       = off - base_i;
  assign pal_hit   = we_i && (off == OFF_W'(PAL_OFF));
  assign size_bad  = (size_i != SZ_HALF);
  assign odd       = addr_i[0];
  assign bank_bad  = (bank_i >= BANK_W'(N_BANKS));
  assign range_bad = (off >= OFF_W'(WIN_WORDS)) && !pal_hit;
  assign in_win    = (off >= base_i) && (rel < OFF_W'(REG_WORDS));
  assign err_o     = size_bad | odd | bank_bad | range_bad;

  always_comb begin
    tgt_o = TGT_BANK;
    idx_o = {bank_i[BSEL_W-1:0], off[LOCAL_AW-1:0]};
    if (err_o) begin
      tgt_o = TGT_NONE;
    end else if (pal_hit) begin
      tgt_o = TGT_PAL;
    end else if (in_win) begin
      tgt_o = TGT_WIN;
      idx_o = IDX_W'(rel[$clog2(REG_WORDS)-1:0]);  // window lands in bank 0
    end
  end
endmodule

// File: rtl/vmem_store.sv
module vmem_store #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 11,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/vmem_palette.sv
module vmem_palette #(
  parameter int N_ENT  = 16,
  parameter int DATA_W = 16,
  localparam int IW    = $clog2(N_ENT)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [N_ENT*DATA_W-1:0] pal_o
);
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   idx_q <= '0;
    else if (wr_i) idx_q <= (idx_q == IW'(N_ENT - 1)) ? '0 : idx_q + 1'b1;
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [DATA_W-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ent_q <= '0;
      else if (wr_i && idx_q == IW'(g))     ent_q <= wdata_i;
    end
    assign pal_o[g*DATA_W +: DATA_W] = ent_q;
  end
endmodule

// File: rtl/vmem_host_if.sv
module vmem_host_if
  import vmem_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 2,
  parameter int N_BANKS   = 2,
  parameter int WIN_WORDS = 65536,
  parameter int REG_WORDS = 16,
  parameter int PAL_OFF   = 32'h40000,
  parameter int PAL_N     = 16,
  parameter int BASE_RST  = 32'h200,
  parameter int LOCAL_AW  = 10,
  localparam int OFF_W    = ADDR_W - 1,
  localparam int BSEL_W   = (N_BANKS > 1) ? $clog2(N_BANKS) : 1,
  localparam int IDX_W    = BSEL_W + LOCAL_AW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              size_i,
  input  logic [DATA_W-1:0]       wdata_i,
  input  logic [BANK_W-1:0]       bank_i,
  input  logic                    base_ld_i,
  input  logic [OFF_W-1:0]        base_i,
  output logic                    rsp_valid_o,
  output logic [DATA_W-1:0]       rdata_o,
  output logic                    err_o,
  output logic [PAL_N*DATA_W-1:0] pal_o
);
  logic [OFF_W-1:0]  base_q;
  logic              dec_err;
  tgt_e              dec_tgt;
  logic [IDX_W-1:0]  dec_idx;
  logic [DATA_W-1:0] mem_rd;
  logic              mem_we, pal_we, mem_re;
  logic              rsp_q, err_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        base_q <= OFF_W'(BASE_RST);
    else if (base_ld_i) base_q <= base_i;
  end

  vmem_decode #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .N_BANKS(N_BANKS), .WIN_WORDS(WIN_WORDS),
    .REG_WORDS(REG_WORDS), .PAL_OFF(PAL_OFF), .LOCAL_AW(LOCAL_AW)
  ) u_dec (
    .we_i(we_i), .addr_i(addr_i), .size_i(size_i), .bank_i(bank_i), .base_i(base_q),
    .err_o(dec_err), .tgt_o(dec_tgt), .idx_o(dec_idx)
  );

  assign pal_we = req_i && we_i && (dec_tgt == TGT_PAL);
  assign mem_we = req_i && we_i && (dec_tgt == TGT_WIN || dec_tgt == TGT_BANK);
  assign mem_re = req_i && !we_i && !dec_err;

  vmem_store #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk_i(clk_i), .we_i(mem_we), .idx_i(dec_idx), .wdata_i(wdata_i), .rdata_o(mem_rd)
  );

  vmem_palette #(.N_ENT(PAL_N), .DATA_W(DATA_W)) u_pal (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(pal_we), .wdata_i(wdata_i), .pal_o(pal_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_q   <= 1'b0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q   <= req_i;
      err_q   <= req_i && dec_err;
      rdata_q <= mem_re ? mem_rd : '0;
    end
  end

  assign rsp_valid_o = rsp_q;
  assign err_o       = err_q;
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/vmem_host_if_chk.sv
module vmem_host_if_chk #(
  parameter int ADDR_W  = 20,
  parameter int DATA_W  = 16,
  parameter int BANK_W  = 2,
  parameter int N_BANKS = 2,
  parameter int PAL_OFF = 32'h40000,
  parameter int PAL_N   = 16
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    req_i,
  input logic                    we_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [1:0]              size_i,
  input logic [BANK_W-1:0]       bank_i,
  input logic                    rsp_valid_o,
  input logic [DATA_W-1:0]       rdata_o,
  input logic                    err_o,
  input logic [PAL_N*DATA_W-1:0] pal_o
);
  AST_RSP_AFTER_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R11
  AST_NO_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o); // R11
  AST_ERR_WITH_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_valid_o); // R11
  AST_WR_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i) |=> (rdata_o == '0)); // R11
  AST_SIZE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != 2'd1) |=> err_o); // R1
  AST_ODD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i[0]) |=> err_o); // R1
  AST_BANK_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && bank_i >= BANK_W'(N_BANKS)) |=> err_o); // R2
  AST_PAL_RD_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[ADDR_W-1:1] == (ADDR_W-1)'(PAL_OFF)) |=> err_o); // R7
  AST_PAL_HOLD_NO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> $stable(pal_o)); // R6
  AST_PAL_HOLD_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $stable(pal_o)); // R8
endmodule

bind vmem_host_if vmem_host_if_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W), .N_BANKS(N_BANKS),
  .PAL_OFF(PAL_OFF), .PAL_N(PAL_N)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .size_i(size_i), .bank_i(bank_i), .rsp_valid_o(rsp_valid_o), .rdata_o(rdata_o),
  .err_o(err_o), .pal_o(pal_o)
);

// File: tb/sim_vmem_host_if.sv
`timescale 1ns/1ps
module sim_vmem_host_if;
  localparam int LAW  = 10;
  localparam int NPAL = 16;
  localparam logic [18:0] PAL = 19'h40000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic        req_i = 0, we_i = 0, base_ld_i = 0;
  logic [19:0] addr_i = '0;
  logic [1:0]  size_i = 2'd1, bank_i = '0;
  logic [15:0] wdata_i = '0;
  logic [18:0] base_i = '0;
  logic        rsp_valid_o, err_o;
  logic [15:0] rdata_o;
  logic [NPAL*16-1:0] pal_o;

  vmem_host_if u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .size_i(size_i), .wdata_i(wdata_i), .bank_i(bank_i), .base_ld_i(base_ld_i),
    .base_i(base_i), .rsp_valid_o(rsp_valid_o), .rdata_o(rdata_o), .err_o(err_o),
    .pal_o(pal_o)
  );

  logic [15:0] m_mem [2*(1<<LAW)];
  logic [15:0] m_pal [NPAL];
  int          m_pidx;
  logic [18:0] m_base;
  int n_chk = 0, n_fail = 0;

  function automatic logic [NPAL*16-1:0] pal_vec();
    logic [NPAL*16-1:0] v;
    for (int i = 0; i < NPAL; i++) v[i*16 +: 16] = m_pal[i];
    return v;
  endfunction

  task automatic judge(input string tag, input logic ok, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %s expected %s", tag, act, exp);
    end
  endtask

  task automatic access(input logic we, input logic [19:0] addr, input logic [1:0] sz,
                        input logic [1:0] bk, input logic [15:0] wd,
                        input logic ld, input logic [18:0] nb, input string tag_in);
    logic [18:0] off, rel;
    logic        pal_hit, err, win;
    int          idx;
    logic [15:0] exp_rd;
    string       tag;
    off     = addr[19:1];
    pal_hit = we && off == PAL;
    err     = (sz != 2'd1) || addr[0] || (bk >= 2'd2) || (off >= 19'h10000 && !pal_hit);
    rel     = off - m_base;
    win     = (off >= m_base) && (rel < 19'd16);
    idx     = win ? int'(rel[3:0]) : int'({bk[0], off[LAW-1:0]});
    exp_rd  = (!err && !we) ? m_mem[idx] : 16'h0;
    if (tag_in != "") tag = tag_in;
    else if (err) tag = ((sz != 2'd1) || addr[0]) ? "R1" : (bk >= 2'd2) ? "R2" :
                        (!we && off == PAL) ? "R7" : "R3";
    else tag = pal_hit ? "R6" : win ? "R4" : "R5";
    @(negedge clk);
    req_i = 1; we_i = we; addr_i = addr; size_i = sz; bank_i = bk; wdata_i = wd;
    base_ld_i = ld; base_i = nb;
    @(negedge clk);
    req_i = 0; base_ld_i = 0;
    if (!err && we) begin
      if (pal_hit) begin m_pal[m_pidx] = wd; m_pidx = (m_pidx + 1) % NPAL; end
      else m_mem[idx] = wd;
    end
    if (ld) m_base = nb;
    judge(tag, rsp_valid_o === 1'b1 && err_o === err && rdata_o === exp_rd && pal_o === pal_vec(),
          $sformatf("v=%0b err=%0b rd=%h pal=%h", rsp_valid_o, err_o, rdata_o, pal_o),
          $sformatf("v=1 err=%0b rd=%h pal=%h", err, exp_rd, pal_vec()));
  endtask

  task automatic rd(input logic [18:0] off, input logic [1:0] bk, input string tag);
    access(1'b0, {off, 1'b0}, 2'd1, bk, 16'h0, 1'b0, 19'h0, tag);
  endtask

  task automatic wr(input logic [18:0] off, input logic [1:0] bk, input logic [15:0] d, input string tag);
    access(1'b1, {off, 1'b0}, 2'd1, bk, d, 1'b0, 19'h0, tag);
  endtask

  task automatic load_base(input logic [18:0] nb);
    @(negedge clk); base_ld_i = 1; base_i = nb;
    @(negedge clk); base_ld_i = 0; m_base = nb;
  endtask

  initial begin
    #(8ns * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    m_base = 19'h200; m_pidx = 0;
    for (int i = 0; i < NPAL; i++) m_pal[i] = '0;
    repeat (3) @(negedge clk);
    // R9: reset state at the ports
    judge("R9", rsp_valid_o === 0 && err_o === 0 && rdata_o === 0 && pal_o === '0,
          $sformatf("v=%0b err=%0b rd=%h pal=%h", rsp_valid_o, err_o, rdata_o, pal_o), "all zero");
    rst_ni = 1;
    @(negedge clk);
    // R9: default base 0x200 -> word 0x205 maps to memory word 5
    wr(19'h205, 2'd1, 16'hBEEF, "R9");
    rd(19'h005, 2'd0, "R9");
    // R11: idle cycle gives no response
    @(negedge clk);
    judge("R11", rsp_valid_o === 0 && err_o === 0, $sformatf("v=%0b err=%0b", rsp_valid_o, err_o), "v=0 err=0");
    // R6/R9: first palette write lands in entry 0
    wr(PAL, 2'd0, 16'h1111, "R6");

    // fill memory with the window moved out of the way
    load_base(19'h8000);
    for (int b = 0; b < 2; b++)
      for (int o = 0; o < (1 << LAW); o++)
        wr(19'(o), 2'(b), 16'($urandom), "R5");

    // R5: aliasing within a bank
    wr(19'h0400 + 19'd7, 2'd1, 16'hA5A5, "R5");
    rd(19'h0007, 2'd1, "R5");
    // R4: window edges and bank independence
    load_base(19'h1230);
    wr(19'h1230, 2'd1, 16'h0F0F, "R4");
    rd(19'h1230, 2'd0, "R4");
    rd(19'h0000, 2'd0, "R4");
    wr(19'h123F, 2'd0, 16'h7777, "R4");
    rd(19'h000F, 2'd0, "R4");
    rd(19'h1240, 2'd0, "R5");
    rd(19'h122F, 2'd1, "R5");
    // R10: access in the cycle of a base load uses the old base
    access(1'b0, {19'h4444, 1'b0}, 2'd1, 2'd0, 16'h0, 1'b1, 19'h4440, "R10");
    rd(19'h4444, 2'd0, "R10");
    access(1'b1, {19'h0300, 1'b0}, 2'd1, 2'd1, 16'h5A5A, 1'b1, 19'h0300, "R10");
    rd(19'h0300, 2'd1, "R10");
    // R3: range boundary
    rd(19'h0FFFF, 2'd0, "R3");
    rd(19'h10000, 2'd0, "R3");
    wr(19'h10000, 2'd1, 16'h9999, "R3");
    // R2 / R1
    rd(19'h0010, 2'd2, "R2");
    wr(19'h0010, 2'd3, 16'h1234, "R2");
    access(1'b0, 20'h00021, 2'd1, 2'd0, 16'h0, 1'b0, 19'h0, "R1");
    access(1'b1, 20'h00020, 2'd0, 2'd0, 16'h4321, 1'b0, 19'h0, "R1");
    access(1'b1, 20'h00020, 2'd2, 2'd0, 16'h4321, 1'b0, 19'h0, "R1");
    rd(19'h0010, 2'd0, "R8");
    // R7: palette port is write-only
    rd(PAL, 2'd0, "R7");
    // R8: errored palette writes leave entry and index alone
    access(1'b1, {PAL, 1'b1}, 2'd1, 2'd0, 16'hDEAD, 1'b0, 19'h0, "R8");
    access(1'b1, {PAL, 1'b0}, 2'd1, 2'd2, 16'hDEAD, 1'b0, 19'h0, "R8");
    // R6: fill and wrap the palette index
    for (int i = 0; i < 17; i++) wr(PAL, 2'(i % 2), 16'hC000 + 16'(i), "R6");

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [18:0] off, nb;
      logic [1:0]  sz, bk;
      logic        we, odd, ld;
      int          sel;
      sel = int'($urandom % 8);
      case (sel)
        0, 1:    off = m_base + 19'($urandom % 20) - 19'd2;
        2, 3, 4: off = 19'($urandom % 32'h10000);
        5:       off = 19'h10000 + 19'($urandom % 32'h70000);
        6:       off = PAL;
        default: off = 19'($urandom % (1 << LAW));
      endcase
      we  = 1'($urandom);
      odd = ($urandom % 16) == 0;
      sz  = (($urandom % 16) == 0) ? 2'($urandom) : 2'd1;
      bk  = (($urandom % 16) == 0) ? 2'd2 + 2'($urandom % 2) : 2'($urandom % 2);
      ld  = ($urandom % 32) == 0;
      nb  = (($urandom % 4) == 0) ? 19'hFFF0 + 19'($urandom % 16) : 19'($urandom % 32'h10000);
      access(we, {off, odd}, sz, bk, 16'($urandom), ld, nb, "");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule